// File: doc/BRIEF.md
# Buffer Memory Access Arbiter

This block decides which requester may use a shared external buffer memory on each access. A host-transfer port and an internal decoding port compete for the memory. An internal refresh timer adds refresh accesses when the memory is dynamic. One grant is active at a time, and every access ends with at least one idle clock. That idle clock is the access boundary where the next owner is chosen.

A configuration byte sets the burst length, refresh rate, data bus width and memory type. The burst length is how many host accesses in a row win over a waiting internal request. The refresh rate is one of two clock divisors. The data bus is byte-wide or nibble-wide. The memory type is static or dynamic. A written byte is held until the arbiter is idle, so an access in progress never sees its setting change. With a nibble-wide bus, one grant covers two memory cycles, low nibble first. Each memory cycle lasts `CYC_LEN` clocks.

Top module: `bma_arbiter`

## Requirements
- R1: The configuration byte has this layout. Bits [1:0] are the burst code, bit 2 selects the slow refresh rate, bit 3 selects the nibble bus, and bit 4 selects static memory. After reset the byte is 0x00.
- R2: Host and internal requests may both be held. Then the host gets burst code + 1 consecutive grants, the internal port gets exactly one grant, and the pattern repeats.
- R3: A lone requester, host or internal, is granted access after access. With no request, no host or internal grant appears.
- R4: `rfsh_tick` is a one-clock pulse. On dynamic memory it repeats every 200 clocks when bit 2 is 0, and every 400 clocks when bit 2 is 1.
- R5: With static memory selected, no `rfsh_tick` occurs and no refresh grant is issued.
- R6: After a `rfsh_tick`, the next access to start is a refresh, even while host and internal requests are held.
- R7: A refresh grant lasts one memory cycle (`CYC_LEN` clocks), even in nibble mode.
- R8: In byte mode, a host or internal grant lasts `CYC_LEN` clocks and `nib_hi` stays 0.
- R9: In nibble mode, a host or internal grant lasts 2×`CYC_LEN` clocks. `nib_hi` is 0 for the first `CYC_LEN` clocks and 1 for the last `CYC_LEN` clocks.
- R10: A configuration write during an access does not change that access. It applies from the next access on.
- R11: At most one grant is high at a time, and at least one idle clock separates two accesses.
- R12: During and right after reset, all grants, `nib_hi` and `rfsh_tick` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Loads `cfg_data` into the waiting configuration |
| cfg_data | input | 8 | Configuration byte |
| host_req | input | 1 | Host port requests an access |
| int_req | input | 1 | Internal port requests an access |
| gnt_host | output | 1 | Host owns the memory |
| gnt_int | output | 1 | Internal port owns the memory |
| gnt_rfsh | output | 1 | A refresh access is in progress |
| nib_hi | output | 1 | High-nibble cycle of a nibble-wide access |
| rfsh_tick | output | 1 | One-clock pulse when a refresh comes due |

## Verification
The bench runs the burst pattern for each burst code, one code after reset each time. A counter that is off by one shows up as one host grant too many or too few before the internal grant. It checks that a refresh that falls due while both ports are saturated still wins the next boundary; a design that ranked refresh below the ports would starve it. A configuration write is placed inside a live host access to catch a design that stretches that access into nibble mode. Static mode, and the refresh-grant length in nibble mode, are checked to catch refresh logic that ignores the memory type or the bus width.

// File: rtl/bma_pkg.sv
package bma_pkg;

    typedef enum logic [1:0] {
        OWN_NONE = 2'd0,
        OWN_HOST = 2'd1,
        OWN_INT  = 2'd2,
        OWN_RFSH = 2'd3
    } owner_e;

    // Packed from MSB: spare[7:5], sram[4], nibble[3], slow[2], burst_code[1:0]
    typedef struct packed {
        logic [2:0] spare;
        logic       sram;
        logic       nibble;
        logic       slow;
        logic [1:0] burst_code;
    } cfg_t;

    localparam int CFG_BITS = $bits(cfg_t);

    function automatic logic [2:0] burst_len(input logic [1:0] code);
        return {1'b0, code} + 3'd1;
    endfunction

    function automatic int unsigned rfsh_last(input logic slow,
                                              input int unsigned fast_div,
                                              input int unsigned slow_div);
        return (slow ? slow_div : fast_div) - 1;
    endfunction

endpackage

// File: rtl/bma_cfg_reg.sv
module bma_cfg_reg
    import bma_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_wr,
    input  logic [CFG_BITS-1:0] cfg_data,
    input  logic                idle,
    output cfg_t                act_cfg,
    output cfg_t                eff_cfg
);
    cfg_t pend_cfg;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_cfg <= '0;
            act_cfg  <= '0;
        end else begin
            if (cfg_wr)
                pend_cfg <= cfg_t'(cfg_data);
            if (idle)
                act_cfg <= pend_cfg;
        end
    end

    // At a boundary the next access is decided with the configuration it will run under
    assign eff_cfg = idle ? pend_cfg : act_cfg;
endmodule

// File: rtl/bma_refresh_timer.sv
module bma_refresh_timer
    import bma_pkg::*;
#(
    parameter int unsigned FAST_DIV = 200,
    parameter int unsigned SLOW_DIV = 400
) (
    input  logic clk,
    input  logic rst,
    input  cfg_t act_cfg,
    input  logic take,
    output logic tick,
    output logic pend
);
    localparam int unsigned MAX_DIV = (SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV;
    localparam int CW = $clog2(MAX_DIV);

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;
    logic          wrap;

    assign lim  = CW'(rfsh_last(act_cfg.slow, FAST_DIV, SLOW_DIV));
    assign wrap = (cnt >= lim);

    always_ff @(posedge clk) begin
        if (rst || act_cfg.sram) begin
            cnt  <= '0;
            tick <= 1'b0;
            pend <= 1'b0;
        end else begin
            cnt  <= wrap ? '0 : cnt + 1'b1;
            tick <= wrap;
            pend <= (pend & ~take) | wrap;
        end
    end
endmodule

// File: rtl/bma_sched.sv
module bma_sched
    import bma_pkg::*;
#(
    parameter int unsigned CYC_LEN = 2
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   host_req,
    input  logic   int_req,
    input  logic   rfsh_pend,
    input  cfg_t   eff_cfg,
    output owner_e owner,
    output logic   nib_hi,
    output logic   idle,
    output logic   take_rfsh
);
    localparam int CCW = (CYC_LEN > 1) ? $clog2(CYC_LEN) : 1;
    localparam logic [CCW-1:0] CYC_END = CCW'(CYC_LEN - 1);

    logic [CCW-1:0] cyc;
    logic           beat;
    logic           last_beat;
    logic [2:0]     host_run;
    logic [2:0]     blen;
    owner_e         pick;

    assign idle = (owner == OWN_NONE);
    assign blen = burst_len(eff_cfg.burst_code);

    always_comb begin
        if (rfsh_pend && !eff_cfg.sram)
            pick = OWN_RFSH;
        else if (host_req && (!int_req || host_run < blen))
            pick = OWN_HOST;
        else if (int_req)
            pick = OWN_INT;
        else
            pick = OWN_NONE;
    end

    assign take_rfsh = idle && (pick == OWN_RFSH);
    assign nib_hi    = beat;

    always_ff @(posedge clk) begin
        if (rst) begin
            owner     <= OWN_NONE;
            cyc       <= '0;
            beat      <= 1'b0;
            last_beat <= 1'b1;
            host_run  <= '0;
        end else if (idle) begin
            owner     <= pick;
            cyc       <= '0;
            beat      <= 1'b0;
            last_beat <= (pick == OWN_RFSH) || !eff_cfg.nibble;
            if (pick == OWN_HOST)
                host_run <= (host_run >= blen) ? blen : host_run + 3'd1;
            else if (pick == OWN_INT)
                host_run <= '0;
        end else if (cyc == CYC_END) begin
            cyc <= '0;
            if (last_beat) begin
                owner <= OWN_NONE;
                beat  <= 1'b0;
            end else begin
                beat      <= 1'b1;
                last_beat <= 1'b1;
            end
        end else begin
            cyc <= cyc + 1'b1;
        end
    end
endmodule

// File: rtl/bma_arbiter.sv
module bma_arbiter
    import bma_pkg::*;
#(
    parameter int unsigned CYC_LEN  = 2,
    parameter int unsigned FAST_DIV = 200,
    parameter int unsigned SLOW_DIV = 400
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_wr,
    input  logic [7:0] cfg_data,
    input  logic       host_req,
    input  logic       int_req,
    output logic       gnt_host,
    output logic       gnt_int,
    output logic       gnt_rfsh,
    output logic       nib_hi,
    output logic       rfsh_tick
);
    cfg_t   act_cfg;
    cfg_t   eff_cfg;
    owner_e owner;
    logic   idle;
    logic   take_rfsh;
    logic   rfsh_pend;

    bma_cfg_reg u_cfg (
        .clk      (clk),
        .rst      (rst),
        .cfg_wr   (cfg_wr),
        .cfg_data (cfg_data),
        .idle     (idle),
        .act_cfg  (act_cfg),
        .eff_cfg  (eff_cfg)
    );

    bma_refresh_timer #(
        .FAST_DIV (FAST_DIV),
        .SLOW_DIV (SLOW_DIV)
    ) u_rfsh (
        .clk     (clk),
        .rst     (rst),
        .act_cfg (act_cfg),
        .take    (take_rfsh),
        .tick    (rfsh_tick),
        .pend    (rfsh_pend)
    );

    bma_sched #(
        .CYC_LEN (CYC_LEN)
    ) u_sched (
        .clk       (clk),
        .rst       (rst),
        .host_req  (host_req),
        .int_req   (int_req),
        .rfsh_pend (rfsh_pend),
        .eff_cfg   (eff_cfg),
        .owner     (owner),
        .nib_hi    (nib_hi),
        .idle      (idle),
        .take_rfsh (take_rfsh)
    );

    assign gnt_host = (owner == OWN_HOST);
    assign gnt_int  = (owner == OWN_INT);
    assign gnt_rfsh = (owner == OWN_RFSH);
endmodule

// File: rtl/bma_arbiter_chk.sv
module bma_arbiter_chk
    import bma_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic gnt_host,
    input logic gnt_int,
    input logic gnt_rfsh,
    input logic nib_hi,
    input logic rfsh_tick,
    input cfg_t act_cfg
);
    logic [2:0] g;
    assign g = {gnt_rfsh, gnt_int, gnt_host};

    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(g)); // R11

    AST_IDLE_BETWEEN: assert property (@(posedge clk) disable iff (rst)
        ((|$past(g)) && (g != $past(g))) |-> (g == 3'b000)); // R11

    AST_TICK_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst)
        rfsh_tick |=> !rfsh_tick); // R4

    AST_STATIC_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        $past(act_cfg.sram) |-> !rfsh_tick); // R5

    AST_NIB_IN_NIBBLE: assert property (@(posedge clk) disable iff (rst)
        nib_hi |-> (act_cfg.nibble && (gnt_host || gnt_int))); // R9

    AST_CFG_HELD_IN_ACCESS: assert property (@(posedge clk) disable iff (rst)
        ((|g) && (|$past(g))) |-> $stable(act_cfg)); // R10
endmodule

bind bma_arbiter bma_arbiter_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .gnt_host  (gnt_host),
    .gnt_int   (gnt_int),
    .gnt_rfsh  (gnt_rfsh),
    .nib_hi    (nib_hi),
    .rfsh_tick (rfsh_tick),
    .act_cfg   (act_cfg)
);

// File: tb/bma_arbiter_tb_top.sv
module bma_arbiter_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CYC = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_data = 8'h00;
    logic       host_req = 1'b0;
    logic       int_req = 1'b0;
    logic       gnt_host, gnt_int, gnt_rfsh, nib_hi, rfsh_tick;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bma_arbiter #(.CYC_LEN(CYC), .FAST_DIV(200), .SLOW_DIV(400)) dut_i (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
        .host_req(host_req), .int_req(int_req),
        .gnt_host(gnt_host), .gnt_int(gnt_int), .gnt_rfsh(gnt_rfsh),
        .nib_hi(nib_hi), .rfsh_tick(rfsh_tick)
    );

    // access log: 1 host, 2 internal, 3 refresh
    int       own_log [64];
    int       len_log [64];
    logic [3:0] nib_log [64];
    int       nlog = 0;
    int       cyc_n = 0;
    int       tick_cnt = 0;
    int       last_tick = -1;
    int       tick_gap = 0;
    int       want_rfsh = 0;
    int       prec_ok = 0;
    int       prec_bad = 0;
    int       overlap_bad = 0;
    logic [2:0] prev = 3'b000;

    always @(negedge clk) begin
        logic [2:0] cur;
        int code;
        cyc_n++;
        cur = {gnt_rfsh, gnt_int, gnt_host};
        if ($countones(cur) > 1) overlap_bad++;
        if (prev != 3'b000 && cur != 3'b000 && cur != prev) overlap_bad++;
        if (cur != 3'b000 && prev == 3'b000) begin
            code = gnt_host ? 1 : (gnt_int ? 2 : 3);
            if (want_rfsh != 0) begin
                if (code == 3) prec_ok++; else prec_bad++;
                want_rfsh = 0;
            end
            if (nlog < 64) begin
                own_log[nlog] = code;
                len_log[nlog] = 0;
                nib_log[nlog] = 4'b0000;
            end
            nlog++;
        end
        if (cur != 3'b000 && nlog > 0 && nlog <= 64) begin
            len_log[nlog-1] = len_log[nlog-1] + 1;
            nib_log[nlog-1] = {nib_log[nlog-1][2:0], nib_hi};
        end
        if (rfsh_tick) begin
            tick_cnt++;
            if (last_tick >= 0) tick_gap = cyc_n - last_tick;
            last_tick = cyc_n;
            want_rfsh = 1;
        end
        prev = cur;
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; host_req = 1'b0; int_req = 1'b0; cfg_wr = 1'b0;
        repeat (3) @(posedge clk);
        nlog = 0; tick_cnt = 0; last_tick = -1; tick_gap = 0;
        want_rfsh = 0; prec_ok = 0; prec_bad = 0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic write_cfg(input logic [7:0] v);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_data = v;
        @(negedge clk);
        cfg_wr = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset_state();
        do_reset();
        chk("R12 grants after reset", {29'd0, gnt_rfsh, gnt_int, gnt_host}, 0);
        chk("R12 nib_hi/tick after reset", {30'd0, nib_hi, rfsh_tick}, 0);
        repeat (10) @(negedge clk);
        chk("R3 no request gives no access", nlog, 0);
    endtask

    task automatic t_single(input bit host);
        do_reset();
        write_cfg(8'h00);
        nlog = 0;
        if (host) host_req = 1'b1; else int_req = 1'b1;
        repeat (12) @(negedge clk);
        host_req = 1'b0; int_req = 1'b0;
        repeat (4) @(negedge clk);
        chk("R3 lone requester served repeatedly", (nlog >= 3) ? 1 : 0, 1);
        chk("R3 lone requester owner", own_log[1], host ? 1 : 2);
        chk("R8 byte grant length", len_log[1], CYC);
        chk("R8 byte nib_hi stays low", int'(nib_log[1]), 0);
    endtask

    task automatic t_burst(input int code);
        int n;
        int hits;
        n = code + 1;
        do_reset();
        write_cfg(8'(code));
        nlog = 0;
        host_req = 1'b1; int_req = 1'b1;
        repeat (40) @(negedge clk);
        host_req = 1'b0; int_req = 1'b0;
        repeat (6) @(negedge clk);
        hits = 0;
        for (int i = 0; i < 2*(n+1); i++) begin
            if (own_log[i] == ((i % (n+1) == n) ? 2 : 1)) hits++;
        end
        chk($sformatf("R2 R1 burst pattern code %0d", code), hits, 2*(n+1));
    endtask

    task automatic t_nibble();
        do_reset();
        write_cfg(8'h08);
        nlog = 0;
        int_req = 1'b1;
        repeat (6) @(negedge clk);
        int_req = 1'b0;
        repeat (8) @(negedge clk);
        chk("R9 R1 nibble grant length", len_log[0], 2*CYC);
        chk("R9 nibble phase order", int'(nib_log[0]), 4'b0011);
    endtask

    task automatic t_rate(input bit slow);
        do_reset();
        write_cfg(slow ? 8'h04 : 8'h00);
        for (int i = 0; i < 1500 && tick_cnt < 3; i++) @(negedge clk);
        chk(slow ? "R4 R1 slow refresh spacing" : "R4 fast refresh spacing",
            tick_gap, slow ? 400 : 200);
    endtask

    task automatic t_rfsh_len();
        do_reset();
        write_cfg(8'h08);
        for (int i = 0; i < 400 && tick_cnt < 1; i++) @(negedge clk);
        repeat (8) @(negedge clk);
        chk("R7 refresh grant owner", own_log[0], 3);
        chk("R7 refresh grant length in nibble mode", len_log[0], CYC);
    endtask

    task automatic t_precedence();
        do_reset();
        write_cfg(8'h01);
        host_req = 1'b1; int_req = 1'b1;
        for (int i = 0; i < 700 && tick_cnt < 3; i++) @(negedge clk);
        repeat (8) @(negedge clk);
        host_req = 1'b0; int_req = 1'b0;
        chk("R6 refresh wins next boundary", prec_ok, 3);
        chk("R6 no port access ahead of refresh", prec_bad, 0);
        chk("R11 one grant at a time, gap between", overlap_bad, 0);
    endtask

    task automatic t_static();
        do_reset();
        write_cfg(8'h10);
        tick_cnt = 0; nlog = 0;
        repeat (600) @(negedge clk);
        chk("R5 R1 no tick with static memory", tick_cnt, 0);
        chk("R5 no refresh access with static memory", nlog, 0);
    endtask

    task automatic t_cfg_mid();
        do_reset();
        write_cfg(8'h00);
        nlog = 0;
        host_req = 1'b1;
        for (int i = 0; i < 10 && !gnt_host; i++) @(negedge clk);
        cfg_wr = 1'b1; cfg_data = 8'h08;
        @(negedge clk);
        cfg_wr = 1'b0;
        repeat (10) @(negedge clk);
        host_req = 1'b0;
        repeat (6) @(negedge clk);
        chk("R10 access in progress keeps byte length", len_log[0], CYC);
        chk("R10 next access uses nibble length", len_log[1], 2*CYC);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=%0d expected=finish", cyc_n);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset_state();
        t_single(1'b1);
        t_single(1'b0);
        for (int c = 0; c < 4; c++) t_burst(c);
        t_nibble();
        t_rate(1'b0);
        t_rate(1'b1);
        t_rfsh_len();
        t_precedence();
        t_static();
        t_cfg_mid();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule